// File: doc/BRIEF.md
# Light Pen Capture and Control Port

This block is the host-facing register interface of a bitmap graphics controller. The host writes one 8-bit control byte. Its upper six bits drive display and pen options directly: the pen indicator lamp, a board-select enable, the external overlay, video inversion, the graphics enable and a forced-white fill. Its two low bits choose what the 8-bit input port returns.

A light-pen detection freezes the raster beam position. The pen's light pulse arrives asynchronously and is synchronized to the block clock. On its first rising edge the block sets a sticky hit flag and, on the same clock edge, captures the live line and dot counters from the raster timing block. While the flag stays set, later pulses leave the captured position alone.

The host reads back one of three things: the captured line, the captured horizontal dot position, or a status nibble. The status nibble holds the hit flag, both retrace flags and the pushbutton. When the low select bit is 0, the flag is cleared and held clear, so selecting the line count re-arms the detector for the next pulse. The same select bit, combined with the fill-white bit, produces an active-low blanking output.

Top module: `lpen_port`

## Requirements
- R1: After reset the control byte is 8'hFF. Every control output reads 1, blank_n reads 1, and the port returns status with the hit flag at 0.
- R2: A write with ctl_we high loads ctl_wdata on the next clock edge. Control bit 7 drives led_n, bit 6 board_en, bit 5 overlay_en, bit 4 invert_n, bit 3 gfx_en and bit 2 fill_white_n.
- R3: With control bits [1:0] = 2'b00, rd_data returns the captured line count (0 is the top line, 255 the bottom line).
- R4: With control bits [1:0] = 2'b01, rd_data returns the captured dot position. Bits [7:3] hold the byte count and bits [2:0] the bit-within-byte count; 0 is the leftmost dot and all ones the rightmost.
- R5: With control bit 1 = 1, rd_data returns status: bit 7 the hit flag, bit 6 vretrace, bit 5 hretrace, bit 4 pen_button_n (0 when pressed), and bits [3:0] zero.
- R6: A rising edge of the synchronized light input sets the hit flag. On the same clock edge, line_cnt and dot_cnt are captured.
- R7: While the hit flag is set, further light pulses change neither captured value.
- R8: While control bit 0 is 0, the hit flag is cleared on the next edge and stays clear. A light pulse seen in that state has no effect (clearing wins over setting).
- R9: blank_n is 0 exactly when control bit 0 is 0 and control bit 2 is 1.
- R10: pen_light passes through a SYNC_STAGES-flop synchronizer. With the default of 2, the hit flag becomes visible after the third rising clock edge following the light input going high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| rd_data | output | 8 | Readback port (line, dot or status) |
| pen_light | input | 1 | Asynchronous light-detect pulse from the pen |
| pen_button_n | input | 1 | Pen pushbutton, low when pressed |
| line_cnt | input | LINE_W | Live raster line counter |
| dot_cnt | input | DOT_W | Live horizontal dot counter {byte, bit} |
| vretrace | input | 1 | Vertical retrace flag |
| hretrace | input | 1 | Horizontal retrace flag |
| led_n | output | 1 | Pen indicator lamp, active low |
| board_en | output | 1 | Board-select enable, active high |
| overlay_en | output | 1 | External video overlay enable |
| invert_n | output | 1 | Video invert, active low |
| gfx_en | output | 1 | Graphics display enable |
| fill_white_n | output | 1 | Forced-white fill, active low |
| blank_n | output | 1 | Screen blanking, active low |

## Verification
The bench builds the block with its defaults: LINE_W = 8, DOT_W = 8 and SYNC_STAGES = 2. With these widths the full 0..255 range of both counters fits the port without padding, so random positions can reach the extreme corners of the screen. With the two-stage synchronizer the latency is short and fixed, so the bench can pin the flag to the exact edge on which it must appear. Random positions, retrace flags and button states are mixed with directed cases: a second pulse while the flag is held, a pulse while the flag is held clear, and the flag's first visible cycle.

// File: rtl/lp_pkg.sv
package lp_pkg;

   // Control byte, bit 7 down to bit 0
   typedef struct packed {
      logic led_n;
      logic board_en;
      logic overlay_en;
      logic invert_n;
      logic gfx_en;
      logic fill_white_n;
      logic sel_hi;
      logic sel_lo;
   } lp_ctl_t;

   typedef enum logic [1:0] {
      RD_LINE  = 2'b00,
      RD_DOT   = 2'b01,
      RD_STAT0 = 2'b10,
      RD_STAT1 = 2'b11
   } lp_rdsel_e;

   localparam int unsigned LP_DATA_W = 8;
   localparam int unsigned LP_STAT_W = 4;

endpackage

// File: rtl/lp_ctl_reg.sv
module lp_ctl_reg
   import lp_pkg::*;
#(
   parameter logic [7:0] RESET_VAL = 8'hFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [7:0]  wdata,
   output lp_ctl_t     ctl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= lp_ctl_t'(RESET_VAL);
      end else if (we) begin
         ctl_q <= lp_ctl_t'(wdata);
      end
   end

endmodule

// File: rtl/lp_sync.sv
module lp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lp_capture.sv
module lp_capture #(
   parameter int unsigned LINE_W = 8,
   parameter int unsigned DOT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              light_s,
   input  logic              arm,
   input  logic [LINE_W-1:0] line_cnt,
   input  logic [DOT_W-1:0]  dot_cnt,
   output logic              hit_q,
   output logic [LINE_W-1:0] cap_line_q,
   output logic [DOT_W-1:0]  cap_dot_q
);

   logic light_d_q;
   logic light_rise;

   assign light_rise = light_s & ~light_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         light_d_q  <= 1'b0;
         hit_q      <= 1'b0;
         cap_line_q <= '0;
         cap_dot_q  <= '0;
      end else begin
         light_d_q <= light_s;
         if (!arm) begin
            hit_q <= 1'b0;
         end else if (light_rise && !hit_q) begin
            hit_q      <= 1'b1;
            cap_line_q <= line_cnt;
            cap_dot_q  <= dot_cnt;
         end
      end
   end

endmodule

// File: rtl/lp_readmux.sv
module lp_readmux
   import lp_pkg::*;
#(
   parameter int unsigned LINE_W = 8,
   parameter int unsigned DOT_W  = 8
) (
   input  lp_rdsel_e         sel,
   input  logic [LINE_W-1:0] cap_line,
   input  logic [DOT_W-1:0]  cap_dot,
   input  logic              hit,
   input  logic              vretrace,
   input  logic              hretrace,
   input  logic              button_n,
   output logic [7:0]        rd_data
);

   logic [7:0] line_ext;
   logic [7:0] dot_ext;
   logic [7:0] stat_word;

   generate
      if (LINE_W == LP_DATA_W) begin : g_line_full
         assign line_ext = cap_line;
      end else begin : g_line_pad
         assign line_ext = {{(LP_DATA_W-LINE_W){1'b0}}, cap_line};
      end
      if (DOT_W == LP_DATA_W) begin : g_dot_full
         assign dot_ext = cap_dot;
      end else begin : g_dot_pad
         assign dot_ext = {{(LP_DATA_W-DOT_W){1'b0}}, cap_dot};
      end
   endgenerate

   assign stat_word = {hit, vretrace, hretrace, button_n, {LP_STAT_W{1'b0}}};

   always_comb begin
      unique case (sel)
         RD_LINE: rd_data = line_ext;
         RD_DOT:  rd_data = dot_ext;
         default: rd_data = stat_word;
      endcase
   end

endmodule

// File: rtl/lpen_port.sv
module lpen_port
   import lp_pkg::*;
#(
   parameter int unsigned LINE_W      = 8,
   parameter int unsigned DOT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  CTL_RESET   = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [7:0]        ctl_wdata,
   output logic [7:0]        rd_data,
   input  logic              pen_light,
   input  logic              pen_button_n,
   input  logic [LINE_W-1:0] line_cnt,
   input  logic [DOT_W-1:0]  dot_cnt,
   input  logic              vretrace,
   input  logic              hretrace,
   output logic              led_n,
   output logic              board_en,
   output logic              overlay_en,
   output logic              invert_n,
   output logic              gfx_en,
   output logic              fill_white_n,
   output logic              blank_n
);

   generate
      if (LINE_W < 1 || LINE_W > LP_DATA_W) begin : g_bad_line
         $error("lpen_port: LINE_W must be 1..8");
      end
      if (DOT_W < 1 || DOT_W > LP_DATA_W) begin : g_bad_dot
         $error("lpen_port: DOT_W must be 1..8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("lpen_port: SYNC_STAGES must be at least 1");
      end
   endgenerate

   lp_ctl_t           ctl_q;
   logic              light_s;
   logic              hit_q;
   logic [LINE_W-1:0] cap_line_q;
   logic [DOT_W-1:0]  cap_dot_q;
   lp_rdsel_e         rd_sel;

   lp_ctl_reg #(.RESET_VAL(CTL_RESET)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_we),
      .wdata (ctl_wdata),
      .ctl_q (ctl_q)
   );

   lp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pen_light),
      .q     (light_s)
   );

   lp_capture #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .light_s    (light_s),
      .arm        (ctl_q.sel_lo),
      .line_cnt   (line_cnt),
      .dot_cnt    (dot_cnt),
      .hit_q      (hit_q),
      .cap_line_q (cap_line_q),
      .cap_dot_q  (cap_dot_q)
   );

   assign rd_sel = lp_rdsel_e'({ctl_q.sel_hi, ctl_q.sel_lo});

   lp_readmux #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_mux (
      .sel      (rd_sel),
      .cap_line (cap_line_q),
      .cap_dot  (cap_dot_q),
      .hit      (hit_q),
      .vretrace (vretrace),
      .hretrace (hretrace),
      .button_n (pen_button_n),
      .rd_data  (rd_data)
   );

   assign led_n        = ctl_q.led_n;
   assign board_en     = ctl_q.board_en;
   assign overlay_en   = ctl_q.overlay_en;
   assign invert_n     = ctl_q.invert_n;
   assign gfx_en       = ctl_q.gfx_en;
   assign fill_white_n = ctl_q.fill_white_n;
   assign blank_n      = ctl_q.sel_lo | ~ctl_q.fill_white_n;

endmodule

// File: rtl/lpen_port_chk.sv
module lpen_port_chk #(
   parameter int unsigned LINE_W = 8,
   parameter int unsigned DOT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        ctl_bits,
   input logic              hit,
   input logic [LINE_W-1:0] cap_line,
   input logic [DOT_W-1:0]  cap_dot,
   input logic [LINE_W-1:0] line_cnt,
   input logic [DOT_W-1:0]  dot_cnt,
   input logic [7:0]        rd_data,
   input logic              blank_n
);

   assert_capture_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit) |-> cap_line == $past(line_cnt));

   assert_capture_dot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hit) |-> cap_dot == $past(dot_cnt));

   assert_hold_position_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && $past(hit)) |-> ($stable(cap_line) && $stable(cap_dot)));

   assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_bits[0] |=> !hit);

   assert_status_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_bits[1] |-> (rd_data[3:0] == 4'h0 && rd_data[7] == hit));

   assert_blank_when_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_bits[0] |-> blank_n);

endmodule

bind lpen_port lpen_port_chk #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_bits (ctl_q),
   .hit      (hit_q),
   .cap_line (cap_line_q),
   .cap_dot  (cap_dot_q),
   .line_cnt (line_cnt),
   .dot_cnt  (dot_cnt),
   .rd_data  (rd_data),
   .blank_n  (blank_n)
);

// File: tb/lpen_port_tb_top.sv
`timescale 1ns/1ps
module lpen_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] rd_data;
   logic       pen_light = 1'b0;
   logic       pen_button_n = 1'b1;
   logic [7:0] line_cnt = 8'h00;
   logic [7:0] dot_cnt = 8'h00;
   logic       vretrace = 1'b0;
   logic       hretrace = 1'b0;
   logic       led_n, board_en, overlay_en, invert_n, gfx_en, fill_white_n, blank_n;

   int n_chk  = 0;
   int n_fail = 0;
   int seed_v;

   always #5 clk = ~clk;

   lpen_port dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_we       (ctl_we),
      .ctl_wdata    (ctl_wdata),
      .rd_data      (rd_data),
      .pen_light    (pen_light),
      .pen_button_n (pen_button_n),
      .line_cnt     (line_cnt),
      .dot_cnt      (dot_cnt),
      .vretrace     (vretrace),
      .hretrace     (hretrace),
      .led_n        (led_n),
      .board_en     (board_en),
      .overlay_en   (overlay_en),
      .invert_n     (invert_n),
      .gfx_en       (gfx_en),
      .fill_white_n (fill_white_n),
      .blank_n      (blank_n)
   );

   function automatic logic [7:0] exp_status(logic h, logic v, logic hr, logic b);
      return {h, v, hr, b, 4'b0000};
   endfunction

   function automatic logic exp_blank_n(logic [7:0] c);
      return !(c[0] == 1'b0 && c[2] == 1'b1);
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_ctl(logic [7:0] v);
      ctl_we = 1'b1;
      ctl_wdata = v;
      tick(1);
      ctl_we = 1'b0;
   endtask

   task automatic pulse();
      pen_light = 1'b1;
      tick(4);
      pen_light = 1'b0;
      tick(2);
   endtask

   function automatic logic [7:0] ctl_out();
      return {led_n, board_en, overlay_en, invert_n, gfx_en, fill_white_n, 2'b00};
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] up, ln, dt;
      seed_v = $urandom(32'd4711);
      tick(3);
      // R1: reset state
      chk("R1 controls", ctl_out(), 8'hFC);
      chk("R1 blank", {7'b0, blank_n}, 8'h01);
      chk("R1 status", rd_data, exp_status(1'b0, 1'b0, 1'b0, 1'b1));
      rst_n = 1'b1;
      tick(2);
      chk("R1 status after release", rd_data, exp_status(1'b0, 1'b0, 1'b0, 1'b1));

      // R10: synchronizer latency
      line_cnt = 8'h00; dot_cnt = 8'h00;
      pen_light = 1'b1;
      tick(2);
      chk("R10 not yet", rd_data, exp_status(1'b0, 1'b0, 1'b0, 1'b1));
      tick(1);
      chk("R10 visible", rd_data, exp_status(1'b1, 1'b0, 1'b0, 1'b1));
      pen_light = 1'b0;
      tick(2);
      wr_ctl(8'hF8);
      chk("R3 corner top-left line", rd_data, 8'h00);

      // R7: a second pulse keeps the first position
      wr_ctl(8'hFB);
      line_cnt = 8'hFF; dot_cnt = 8'hFF;
      pulse();
      line_cnt = 8'h12; dot_cnt = 8'h34;
      pulse();
      wr_ctl(8'hF9);
      chk("R7 dot held", rd_data, 8'hFF);
      wr_ctl(8'hF8);
      chk("R7 line held", rd_data, 8'hFF);

      // R8: a pulse while select bit 0 is low is ignored
      wr_ctl(8'hFA);
      line_cnt = 8'h55; dot_cnt = 8'hAA;
      pulse();
      chk("R8 blocked pulse", rd_data, exp_status(1'b0, 1'b0, 1'b0, 1'b1));
      wr_ctl(8'hFB);
      chk("R8 still clear", rd_data, exp_status(1'b0, 1'b0, 1'b0, 1'b1));
      wr_ctl(8'hF9);
      chk("R8 dot unchanged", rd_data, 8'hFF);

      // random mix
      for (int i = 0; i < 24; i++) begin
         up = 8'($urandom) & 8'hFC;
         ln = 8'($urandom);
         dt = 8'($urandom);
         vretrace = 1'($urandom);
         hretrace = 1'($urandom);
         pen_button_n = 1'($urandom);
         line_cnt = ln; dot_cnt = dt;
         wr_ctl(up | 8'h03);
         chk("R2 control fields", ctl_out(), up);
         chk("R5 status idle", rd_data, exp_status(1'b0, vretrace, hretrace, pen_button_n));
         pulse();
         line_cnt = 8'($urandom); dot_cnt = 8'($urandom);
         chk("R6 hit set", rd_data, exp_status(1'b1, vretrace, hretrace, pen_button_n));
         wr_ctl(up | 8'h01);
         chk("R4 dot readback", rd_data, dt);
         chk("R9 blank armed", {7'b0, blank_n}, {7'b0, exp_blank_n(up | 8'h01)});
         wr_ctl(up);
         chk("R3 line readback", rd_data, ln);
         chk("R9 blank line sel", {7'b0, blank_n}, {7'b0, exp_blank_n(up)});
         wr_ctl(up | 8'h03);
         chk("R8 cleared by line select", rd_data, exp_status(1'b0, vretrace, hretrace, pen_button_n));
      end
      summary();
   end

endmodule